// File: doc/BRIEF.md
# Alpha Tile Overlay Compositor

This block lays glyph tiles over a stream of background pixels. The screen is divided into square cells of 32 x 32 pixels. A small cell table holds, for every cell, the number of the tile drawn there and a tint colour in RGB565. Tile bitmaps live in an external memory that stores only a 4-bit coverage (alpha) value per pixel. The colour of a glyph therefore comes entirely from the tint of its cell.

For each incoming pixel the block works out which cell the pixel falls in and reads that cell's entry. It issues the bitmap address in the same cycle as the pixel. The memory answers one cycle later, when the pixel has reached the blend stage, so the read costs no extra cycles. Before blending, the background is dimmed by an 8-bit ambient light level. The blend then mixes tint and dimmed background per colour channel in proportion to the alpha value. Cells holding the reserved tile number of all ones show only the dimmed background.

Top module: `ovl_compositor`

## Requirements
- R1: After reset every cell holds the empty tile number (127), `outValid` is low, and a pixel in any cell yields the dimmed background with `bmpRdEn` low.
- R2: Each pixel accepted with `pixValid` high produces exactly one output with `outValid` high two clock cycles later. Outputs keep input order, and `outValid` is low in every other cycle.
- R3: In the cycle a valid pixel is presented, the cell is column x/32 and row y/32, with cell number row*10+col. `bmpAddr` equals tile*1024 + (y mod 32)*32 + (x mod 32), and `bmpRdEn` is high for a non-empty cell. `bmpAlpha` is taken one cycle later.
- R4: Pixels use RGB565: red in bits [15:11], green in [10:5], blue in [4:0]. Each output channel is (a*T + (15-a)*B + 7) / 15, with integer division. Here a is the alpha, T the tint channel and B the dimmed background channel.
- R5: Alpha 15 outputs the tint exactly, and alpha 0 outputs the dimmed background exactly.
- R6: Each background channel is dimmed to (B*(light+1)) >> 8 before the blend. A light level of 255 leaves the background unchanged.
- R7: A cell whose tile number is 127 passes the dimmed background, keeps `bmpRdEn` low, and ignores whatever value is on `bmpAlpha`.
- R8: Pixels whose column is 10 or more, or whose row is 8 or more, are treated as empty cells.
- R9: A cell write (`cellWrEn`) is seen by a pixel presented in the next cycle. A write to a cell number of 80 or more changes no cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cellWrEn | input | 1 | Write strobe for the cell table |
| cellWrAddr | input | 7 | Cell number to write |
| cellWrTile | input | 7 | Tile number to store (127 = empty) |
| cellWrTint | input | 16 | Tint colour to store, RGB565 |
| pixValid | input | 1 | A pixel is presented this cycle |
| pixX | input | 9 | Pixel column |
| pixY | input | 9 | Pixel row |
| bgPixel | input | 16 | Background pixel, RGB565 |
| lightLevel | input | 8 | Ambient light level, unsigned |
| bmpRdEn | output | 1 | Bitmap memory read enable |
| bmpAddr | output | 17 | Bitmap memory address |
| bmpAlpha | input | 4 | Alpha returned by the bitmap memory one cycle after the read |
| outValid | output | 1 | Composited pixel valid |
| outPixel | output | 16 | Composited pixel, RGB565 |

## Verification
`bmpAddr` and `bmpRdEn` are combinational from the pixel inputs. The bench therefore checks them shortly after driving a pixel, in that same cycle. The memory model in the bench registers alpha on the next rising edge, and the composited pixel appears after the second rising edge. Every pixel is therefore checked two falling edges after it was driven, whether it came from the streamed vector table or a single directed pixel. Cell writes are followed by a pixel one falling edge later, which confirms the one-cycle visibility.

// File: rtl/ovl_pkg.sv
package ovl_pkg;

  typedef struct packed {
    logic [4:0] r;
    logic [5:0] g;
    logic [4:0] b;
  } rgb565_t;

  // control-to-datapath strobes
  typedef struct packed {
    logic captureBg;   // stage 0: a pixel is presented now
    logic loadStage;   // stage 1: blend the pixel held in the stage registers
    logic clearAlpha;  // stage 1: the held pixel lies in an empty cell
  } ovlStrobe_t;

endpackage

// File: rtl/ovl_ctrl.sv
module ovl_ctrl
  import ovl_pkg::*;
#(
  parameter int COLS      = 10,
  parameter int ROWS      = 8,
  parameter int TILE_LOG2 = 5,
  parameter int IDX_W     = 7,
  parameter int PIX_W     = 9,
  parameter int TINT_W    = 16,
  localparam int NUM_CELLS = COLS * ROWS,
  localparam int CELL_AW   = $clog2(NUM_CELLS),
  localparam int ADDR_W    = IDX_W + 2 * TILE_LOG2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cellWrEn,
  input  logic [CELL_AW-1:0] cellWrAddr,
  input  logic [IDX_W-1:0]   cellWrTile,
  input  logic [TINT_W-1:0]  cellWrTint,
  input  logic               pixValid,
  input  logic [PIX_W-1:0]   pixX,
  input  logic [PIX_W-1:0]   pixY,
  output logic               bmpRdEn,
  output logic [ADDR_W-1:0]  bmpAddr,
  output ovlStrobe_t         strobe,
  output logic [TINT_W-1:0]  tintQ
);

  localparam int CRD_W = PIX_W - TILE_LOG2;
  localparam logic [IDX_W-1:0] EMPTY_IDX = '1;

  logic [IDX_W-1:0]  tileTab [NUM_CELLS];
  logic [TINT_W-1:0] tintTab [NUM_CELLS];

  logic [CRD_W-1:0]   cellCol, cellRow;
  logic               inRange, emptyCell;
  logic [CELL_AW-1:0] cellIdx;
  logic [IDX_W-1:0]   curTile;
  logic [TINT_W-1:0]  curTint;
  logic               wrOk;
  int                 cellLin;

  assign cellCol = pixX[PIX_W-1:TILE_LOG2];
  assign cellRow = pixY[PIX_W-1:TILE_LOG2];
  assign inRange = (int'(cellCol) < COLS) && (int'(cellRow) < ROWS);
  assign wrOk    = cellWrEn && (int'(cellWrAddr) < NUM_CELLS);

  always_comb begin
    cellLin = int'(cellRow) * COLS + int'(cellCol);
    cellIdx = CELL_AW'(cellLin);
    curTile = inRange ? tileTab[cellIdx] : EMPTY_IDX;
    curTint = inRange ? tintTab[cellIdx] : '0;
  end

  assign emptyCell = (curTile == EMPTY_IDX);
  // address goes out with the pixel so alpha is back for the blend stage
  assign bmpAddr   = {curTile, pixY[TILE_LOG2-1:0], pixX[TILE_LOG2-1:0]};
  assign bmpRdEn   = pixValid && !emptyCell;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_CELLS; i++) begin
        tileTab[i] <= EMPTY_IDX;
        tintTab[i] <= '0;
      end
    end else if (wrOk) begin
      tileTab[cellWrAddr] <= cellWrTile;
      tintTab[cellWrAddr] <= cellWrTint;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      strobe.loadStage  <= 1'b0;
      strobe.clearAlpha <= 1'b0;
      tintQ             <= '0;
    end else begin
      strobe.loadStage  <= pixValid;
      strobe.clearAlpha <= emptyCell;
      tintQ             <= curTint;
    end
  end

  assign strobe.captureBg = pixValid;

  // a cell just written empty must not trigger a bitmap read
  p_empty_write_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cellWrEn && cellWrTile == EMPTY_IDX && int'(cellWrAddr) < NUM_CELLS)
      |=> !(pixValid && inRange && cellIdx == $past(cellWrAddr) && bmpRdEn));

  p_offscreen_no_read_r8: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && int'(pixX) >= (COLS << TILE_LOG2)) |-> !bmpRdEn);

endmodule

// File: rtl/ovl_datapath.sv
module ovl_datapath
  import ovl_pkg::*;
#(
  parameter int LIGHT_W = 8,
  parameter int ALPHA_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  ovlStrobe_t         strobe,
  input  logic [15:0]        bgPixel,
  input  logic [LIGHT_W-1:0] lightLevel,
  input  logic [15:0]        tint,
  input  logic [ALPHA_W-1:0] bmpAlpha,
  output logic               outValid,
  output logic [15:0]        outPixel
);

  localparam int ALPHA_MAX = (1 << ALPHA_W) - 1;
  localparam int PROD_W    = LIGHT_W + 7;
  localparam int ACC_W     = ALPHA_W + 8;

  function automatic logic [5:0] scaleCh(logic [5:0] c, logic [LIGHT_W-1:0] lv);
    logic [PROD_W-1:0] prod;
    prod = PROD_W'(c) * (PROD_W'(lv) + PROD_W'(1));
    return 6'(prod >> LIGHT_W);
  endfunction

  function automatic logic [5:0] blendCh(logic [ALPHA_W-1:0] a, logic [5:0] f, logic [5:0] b);
    logic [ACC_W-1:0] acc;
    acc = ACC_W'(a) * ACC_W'(f)
        + ACC_W'(ALPHA_W'(ALPHA_MAX) - a) * ACC_W'(b)
        + ACC_W'(ALPHA_MAX / 2);
    return 6'(acc / ACC_W'(ALPHA_MAX));
  endfunction

  rgb565_t bgIn, bgScaled, bgQ, tintC, blended;
  logic [ALPHA_W-1:0] alphaEff;

  assign bgIn  = bgPixel;
  assign tintC = tint;

  always_comb begin
    bgScaled.r = 5'(scaleCh({1'b0, bgIn.r}, lightLevel));
    bgScaled.g = scaleCh(bgIn.g, lightLevel);
    bgScaled.b = 5'(scaleCh({1'b0, bgIn.b}, lightLevel));
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 bgQ <= '0;
    else if (strobe.captureBg) bgQ <= bgScaled;
  end

  assign alphaEff = strobe.clearAlpha ? '0 : bmpAlpha;

  always_comb begin
    blended.r = 5'(blendCh(alphaEff, {1'b0, tintC.r}, {1'b0, bgQ.r}));
    blended.g = blendCh(alphaEff, tintC.g, bgQ.g);
    blended.b = 5'(blendCh(alphaEff, {1'b0, tintC.b}, {1'b0, bgQ.b}));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outPixel <= '0;
    end else begin
      outValid <= strobe.loadStage;
      if (strobe.loadStage) outPixel <= blended;
    end
  end

  p_full_alpha_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadStage && !strobe.clearAlpha && bmpAlpha == ALPHA_W'(ALPHA_MAX))
      |=> outPixel == $past(tint));

  p_zero_alpha_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadStage && (strobe.clearAlpha || bmpAlpha == '0))
      |=> outPixel == $past(bgQ));

  p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadStage |=> outValid);

  p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadStage |=> !outValid);

  p_light_full_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.captureBg && lightLevel == '1) |=> bgQ == $past(bgPixel));

endmodule

// File: rtl/ovl_compositor.sv
module ovl_compositor
  import ovl_pkg::*;
#(
  parameter int COLS      = 10,
  parameter int ROWS      = 8,
  parameter int TILE_LOG2 = 5,
  parameter int IDX_W     = 7,
  parameter int PIX_W     = 9,
  parameter int LIGHT_W   = 8,
  parameter int ALPHA_W   = 4,
  localparam int CELL_AW  = $clog2(COLS * ROWS),
  localparam int ADDR_W   = IDX_W + 2 * TILE_LOG2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cellWrEn,
  input  logic [CELL_AW-1:0] cellWrAddr,
  input  logic [IDX_W-1:0]   cellWrTile,
  input  logic [15:0]        cellWrTint,
  input  logic               pixValid,
  input  logic [PIX_W-1:0]   pixX,
  input  logic [PIX_W-1:0]   pixY,
  input  logic [15:0]        bgPixel,
  input  logic [LIGHT_W-1:0] lightLevel,
  output logic               bmpRdEn,
  output logic [ADDR_W-1:0]  bmpAddr,
  input  logic [ALPHA_W-1:0] bmpAlpha,
  output logic               outValid,
  output logic [15:0]        outPixel
);

  ovlStrobe_t  strobe;
  logic [15:0] tintQ;

  ovl_ctrl #(
    .COLS(COLS), .ROWS(ROWS), .TILE_LOG2(TILE_LOG2),
    .IDX_W(IDX_W), .PIX_W(PIX_W), .TINT_W(16)
  ) ctrl_i (
    .clk(clk), .rstN(rstN),
    .cellWrEn(cellWrEn), .cellWrAddr(cellWrAddr),
    .cellWrTile(cellWrTile), .cellWrTint(cellWrTint),
    .pixValid(pixValid), .pixX(pixX), .pixY(pixY),
    .bmpRdEn(bmpRdEn), .bmpAddr(bmpAddr),
    .strobe(strobe), .tintQ(tintQ)
  );

  ovl_datapath #(
    .LIGHT_W(LIGHT_W), .ALPHA_W(ALPHA_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .bgPixel(bgPixel), .lightLevel(lightLevel),
    .tint(tintQ), .bmpAlpha(bmpAlpha),
    .outValid(outValid), .outPixel(outPixel)
  );

endmodule

// File: tb/ovl_compositor_tb_top.sv
module ovl_compositor_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 12;

  logic        clk = 1'b0;
  logic        rstN;
  logic        cellWrEn;
  logic [6:0]  cellWrAddr;
  logic [6:0]  cellWrTile;
  logic [15:0] cellWrTint;
  logic        pixValid;
  logic [8:0]  pixX, pixY;
  logic [15:0] bgPixel;
  logic [7:0]  lightLevel;
  logic        bmpRdEn;
  logic [16:0] bmpAddr;
  logic [3:0]  bmpAlpha;
  logic        outValid;
  logic [15:0] outPixel;

  int errCnt = 0;
  int chkCnt = 0;
  bit done = 0;

  logic [6:0]  shTile [80];
  logic [15:0] shTint [80];

  // vector: x(9) y(9) background(16) light(8)
  localparam logic [41:0] VEC [NVEC] = '{
    {9'd5,   9'd0,  16'h0000, 8'd255},
    {9'd15,  9'd0,  16'h1234, 8'd255},
    {9'd40,  9'd3,  16'hABCD, 8'd128},
    {9'd70,  9'd33, 16'hFFFF, 8'd0},
    {9'd10,  9'd40, 16'h8410, 8'd200},
    {9'd300, 9'd10, 16'hFFFF, 8'd255},
    {9'd400, 9'd5,  16'hF00F, 8'd255},
    {9'd33,  9'd63, 16'h7BEF, 8'd64},
    {9'd0,   9'd0,  16'hF800, 8'd127},
    {9'd31,  9'd31, 16'h07E0, 8'd255},
    {9'd64,  9'd0,  16'hFFFF, 8'd255},
    {9'd45,  9'd300,16'h5555, 8'd255}
  };

  ovl_compositor dut_i (
    .clk(clk), .rstN(rstN),
    .cellWrEn(cellWrEn), .cellWrAddr(cellWrAddr),
    .cellWrTile(cellWrTile), .cellWrTint(cellWrTint),
    .pixValid(pixValid), .pixX(pixX), .pixY(pixY),
    .bgPixel(bgPixel), .lightLevel(lightLevel),
    .bmpRdEn(bmpRdEn), .bmpAddr(bmpAddr), .bmpAlpha(bmpAlpha),
    .outValid(outValid), .outPixel(outPixel)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // bitmap memory model: one-cycle read, alpha computed from the address
  function automatic logic [3:0] alphaOf(int addr);
    return 4'((addr % 16) ^ ((addr / 1024) % 16));
  endfunction

  always @(posedge clk) if (bmpRdEn) bmpAlpha <= alphaOf(int'(bmpAddr));

  function automatic int mixCh(int a, int f, int b);
    return (a * f + (15 - a) * b + 7) / 15;
  endfunction

  function automatic logic [15:0] model(int x, int y, logic [15:0] bg, logic [7:0] lv);
    int col = x / 32;
    int row = y / 32;
    int tile = 127;
    int a = 0;
    int r, g, b;
    logic [15:0] tn = 16'h0;
    if (col < 10 && row < 8) begin
      tile = int'(shTile[row * 10 + col]);
      tn = shTint[row * 10 + col];
    end
    r = int'(bg[15:11]) * (int'(lv) + 1) / 256;
    g = int'(bg[10:5])  * (int'(lv) + 1) / 256;
    b = int'(bg[4:0])   * (int'(lv) + 1) / 256;
    if (tile != 127) a = int'(alphaOf(tile * 1024 + (y % 32) * 32 + (x % 32)));
    r = mixCh(a, int'(tn[15:11]), r);
    g = mixCh(a, int'(tn[10:5]), g);
    b = mixCh(a, int'(tn[4:0]), b);
    return {5'(r), 6'(g), 5'(b)};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    chkCnt++;
    if (act !== exp) begin
      errCnt++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic writeCell(int addr, logic [6:0] tile, logic [15:0] tint);
    @(negedge clk);
    cellWrEn = 1'b1; cellWrAddr = 7'(addr); cellWrTile = tile; cellWrTint = tint;
    if (addr < 80) begin shTile[addr] = tile; shTint[addr] = tint; end
    @(negedge clk);
    cellWrEn = 1'b0;
  endtask

  task automatic drivePix(int x, int y, logic [15:0] bg, logic [7:0] lv);
    pixValid = 1'b1; pixX = 9'(x); pixY = 9'(y); bgPixel = bg; lightLevel = lv;
  endtask

  // one pixel, result checked two falling edges later
  task automatic onePix(string req, int x, int y, logic [15:0] bg, logic [7:0] lv,
                        logic [15:0] exp);
    @(negedge clk);
    drivePix(x, y, bg, lv);
    @(negedge clk);
    pixValid = 1'b0;
    @(negedge clk);
    check(req, {31'd0, outValid}, 32'd1);
    check(req, {16'd0, outPixel}, {16'd0, exp});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errCnt++;
      $display("FAIL R2 watchdog expired: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 80; i++) begin shTile[i] = 7'd127; shTint[i] = 16'h0; end
    rstN = 1'b0; cellWrEn = 1'b0; cellWrAddr = '0; cellWrTile = '0; cellWrTint = '0;
    pixValid = 1'b0; pixX = '0; pixY = '0; bgPixel = '0; lightLevel = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    check("R1 outValid after reset", {31'd0, outValid}, 32'd0);
    @(negedge clk);
    drivePix(20, 20, 16'hF800, 8'd127);
    #1 check("R1 no read in empty table", {31'd0, bmpRdEn}, 32'd0);
    @(negedge clk); pixValid = 1'b0;
    @(negedge clk);
    check("R1 empty cell output", {16'd0, outPixel}, 32'h7800);

    // table setup
    writeCell(0, 7'd0, 16'hFFFF);
    writeCell(1, 7'd5, 16'h07E0);
    writeCell(10, 7'd71, 16'h001F);
    writeCell(11, 7'd40, 16'hF81F);

    // R2 R4 R6 R8: streamed vector table
    for (int i = 0; i < NVEC + 2; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        check("R2 stream valid", {31'd0, outValid}, 32'd1);
        check("R4 stream pixel", {16'd0, outPixel},
              {16'd0, model(int'(VEC[i-2][41:33]), int'(VEC[i-2][32:24]),
                            VEC[i-2][23:8], VEC[i-2][7:0])});
      end
      if (i < NVEC) drivePix(int'(VEC[i][41:33]), int'(VEC[i][32:24]), VEC[i][23:8], VEC[i][7:0]);
      else pixValid = 1'b0;
    end
    @(negedge clk);
    check("R2 valid drops after stream", {31'd0, outValid}, 32'd0);

    // R3: address and read enable in the pixel's own cycle
    @(negedge clk);
    drivePix(40, 3, 16'h0, 8'd255);
    #1;
    check("R3 bmpAddr", {15'd0, bmpAddr}, 32'd5224);
    check("R3 bmpRdEn", {31'd0, bmpRdEn}, 32'd1);
    @(negedge clk); pixValid = 1'b0;

    // R5 / R4 / R6 hand values (cell 0, tile 0: alpha = x mod 16)
    onePix("R5 alpha 15 gives tint", 15, 0, 16'h0000, 8'd255, 16'hFFFF);
    onePix("R5 alpha 0 gives background", 0, 0, 16'hF800, 8'd255, 16'hF800);
    onePix("R6 light 127 halves red", 0, 0, 16'hF800, 8'd127, 16'h7800);
    onePix("R4 alpha 5 blend", 5, 0, 16'h0000, 8'd255, 16'h52AA);

    // R8: beyond the last row
    onePix("R8 off-screen row", 15, 256, 16'h1234, 8'd255, 16'h1234);

    // R9: write visible next cycle
    @(negedge clk);
    cellWrEn = 1'b1; cellWrAddr = 7'd2; cellWrTile = 7'd0; cellWrTint = 16'hFFFF;
    shTile[2] = 7'd0; shTint[2] = 16'hFFFF;
    @(negedge clk);
    cellWrEn = 1'b0;
    drivePix(64 + 15, 0, 16'h0000, 8'd255);
    @(negedge clk); pixValid = 1'b0;
    @(negedge clk);
    check("R9 write seen next cycle", {16'd0, outPixel}, 32'hFFFF);

    // R9: write to a cell number past the table is ignored
    writeCell(85, 7'd0, 16'hFFFF);
    onePix("R9 ignored write", 160 + 15, 0, 16'h4208, 8'd255, 16'h4208);

    // R7: cell made empty, stale alpha ignored
    onePix("R7 prime alpha", 15, 0, 16'h0000, 8'd255, 16'hFFFF);
    writeCell(0, 7'd127, 16'hFFFF);
    @(negedge clk);
    drivePix(15, 0, 16'h0841, 8'd255);
    #1 check("R7 no read for empty", {31'd0, bmpRdEn}, 32'd0);
    @(negedge clk); pixValid = 1'b0;
    @(negedge clk);
    check("R7 empty passes background", {16'd0, outPixel}, 32'h0841);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end

endmodule